// File: doc/BRIEF.md
# Single-Cycle Processor Core with Sticky Halt

This block is a small single-cycle processor for a load/store, three-operand integer instruction subset. On every enabled clock it takes one instruction from its unified word store, splits it into fields, decodes it, reads two operands from a 32-entry register file, forms a sign-extended immediate, computes through the ALU, optionally reads or writes one data word, writes back a register and moves the program counter. Everything an instruction changes is committed on the same rising edge.

Illegal situations do not trap. They latch a halt flag. A fetch beyond the 64 KiB address space, a data access that is unaligned or beyond that space, an opcode that is not decoded and an R-type function code that is not decoded all count as illegal. The instruction that hits the condition commits nothing. The flag stays set until reset and blocks all further steps. A host port writes and reads store words by word index, so a program and its data can be placed before stepping starts. A probe port reads any register combinationally. The backing store is a power-of-two number of words. A byte address selects word `(address >> 2)` modulo that depth, so the full 64 KiB space is decoded by aliasing onto a smaller array.

Top module: `sc_core`

## Requirements
- R1: In the first cycle after a clock edge with `rst_n` low, `pc_o` is 0x4000 and `halt_o` is 0. Register 29 reads 0xFFFC, register 28 reads 0xC000 and every other register reads 0.
- R2: Architectural state changes only on an edge where `step_en` is 1, `host_we` is 0 and `halt_o` is 0. When `host_we` is 1, the edge writes `host_wdata` into store word `host_idx`, and `host_rdata` shows store word `host_idx` combinationally.
- R3: The instruction fields sit at these positions: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0]. Opcode 0x00 writes rd with rs op rt. The function codes are add 0x20, sub 0x22, and 0x24, or 0x25, nor 0x27, signed set-less-than 0x2a and unsigned set-less-than 0x2b. Add and sub wrap modulo 2^32.
- R4: The immediate is bits [15:0] and the result goes to rt. Opcode 0x08 adds the sign-extended immediate. Opcode 0x0a is a signed set-less-than against the sign-extended immediate. Opcode 0x0b is an unsigned set-less-than against the sign-extended immediate. Opcode 0x0f places the immediate in bits [31:16] and zeros the low half.
- R5: The data address is rs plus the sign-extended immediate. Opcode 0x23 loads the word at that address into rt. Opcode 0x2b stores rt to that address. The store word used is (address >> 2) modulo the store depth.
- R6: Opcode 0x04 compares rs with rt. If they are equal, the next PC is PC + 4 + (sign-extended immediate << 2). Otherwise it is PC + 4.
- R7: Opcode 0x02 sets the PC to {(PC + 4)[31:28], target[25:0], 2'b00}.
- R8: Writes that name register 0 are discarded, and register 0 always reads 0.
- R9: A step whose PC is at or above 0x10000, or is not a multiple of 4, sets `halt_o` and changes no register, store word or PC.
- R10: A load or store whose address is not a multiple of 4, or is at or above 0x10000, sets `halt_o` and changes no register, store word or PC.
- R11: An opcode outside R3 to R7, or an opcode-0x00 function code outside R3, sets `halt_o` and changes no register, store word or PC.
- R12: Once `halt_o` is 1 it stays 1, and the PC and registers stay unchanged, until the next reset.
- R13: `pc_o` is always a multiple of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Execute one instruction at this edge |
| host_we | input | 1 | Host store write; overrides a step in the same cycle |
| host_idx | input | STORE_IDX_W | Host store word index |
| host_wdata | input | 32 | Host store write data |
| host_rdata | output | 32 | Store word at `host_idx` |
| probe_sel | input | 5 | Register number to observe |
| probe_data | output | 32 | Value of register `probe_sel` |
| pc_o | output | 32 | Current program counter |
| halt_o | output | 1 | Sticky halt flag |

## Verification
The hardest situations to reach from the ports are the ones where an instruction must be rejected after decode and ALU have already produced a value. Examples are a store that lands exactly one word past the top of the space, and a fetch after a jump has carried the PC to 0x10000. The stimulus creates these deliberately. A store goes through the stack pointer with offset +4. A jump uses a target word of 0x4000. An unaligned load goes through the global pointer. The bench then checks the aliased store word and every register through the probe port, to show nothing was committed. The random phase keeps rt and rd below 16, so the two pointer registers keep their reset values and random loads and stores stay legal.

// File: rtl/sc_pkg.sv
// Shared encodings and types for the single-cycle core.
// Assumes a 32-bit datapath and 32 architectural registers.
package sc_pkg;
    localparam int XLEN      = 32;
    localparam int NREGS     = 32;
    localparam int REG_IDX_W = $clog2(NREGS);

    // Opcode values (bits 31:26)
    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_JUMP  = 6'h02;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_SLTI  = 6'h0a;
    localparam logic [5:0] OP_SLTIU = 6'h0b;
    localparam logic [5:0] OP_LUI   = 6'h0f;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2b;

    // Function values (bits 5:0) for opcode 0
    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_SUB  = 6'h22;
    localparam logic [5:0] FN_AND  = 6'h24;
    localparam logic [5:0] FN_OR   = 6'h25;
    localparam logic [5:0] FN_NOR  = 6'h27;
    localparam logic [5:0] FN_SLT  = 6'h2a;
    localparam logic [5:0] FN_SLTU = 6'h2b;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SLT, ALU_SLTU, ALU_PASSB
    } alu_op_e;

    // Control bundle produced by the decoder
    typedef struct packed {
        logic    legal;     // opcode/function recognised
        logic    reg_we;    // writes a register
        logic    dst_rd;    // destination is rd (else rt)
        logic    b_imm;     // ALU operand B is the immediate
        logic    imm_hi;    // immediate goes to the upper half
        logic    mem_rd;    // load
        logic    mem_wr;    // store
        logic    branch;    // conditional branch on equality
        logic    jump;      // unconditional region jump
        alu_op_e alu_op;
    } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
// Instruction decoder: maps opcode and function to a control bundle.
// Assumes the field positions of the package; purely combinational.
module sc_decode
    import sc_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctrl
);
    logic [5:0] opc;
    logic [5:0] fn;

    assign opc = instr[31:26];
    assign fn  = instr[5:0];

    // Derive every control field from the opcode and function code
    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        case (opc)
            OP_RTYPE: begin
                ctrl.legal  = 1'b1;
                ctrl.reg_we = 1'b1;
                ctrl.dst_rd = 1'b1;
                case (fn)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_NOR:  ctrl.alu_op = ALU_NOR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    FN_SLTU: ctrl.alu_op = ALU_SLTU;
                    default: begin
                        ctrl.legal  = 1'b0;
                        ctrl.reg_we = 1'b0;
                    end
                endcase
            end
            OP_ADDI, OP_SLTI, OP_SLTIU: begin
                ctrl.legal  = 1'b1;
                ctrl.reg_we = 1'b1;
                ctrl.b_imm  = 1'b1;
                ctrl.alu_op = (opc == OP_ADDI) ? ALU_ADD :
                              (opc == OP_SLTI) ? ALU_SLT : ALU_SLTU;
            end
            OP_LUI: begin
                ctrl.legal  = 1'b1;
                ctrl.reg_we = 1'b1;
                ctrl.b_imm  = 1'b1;
                ctrl.imm_hi = 1'b1;
                ctrl.alu_op = ALU_PASSB;
            end
            OP_LOAD: begin
                ctrl.legal  = 1'b1;
                ctrl.reg_we = 1'b1;
                ctrl.b_imm  = 1'b1;
                ctrl.mem_rd = 1'b1;
            end
            OP_STORE: begin
                ctrl.legal  = 1'b1;
                ctrl.b_imm  = 1'b1;
                ctrl.mem_wr = 1'b1;
            end
            OP_BEQ: begin
                ctrl.legal  = 1'b1;
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OP_JUMP: begin
                ctrl.legal = 1'b1;
                ctrl.jump  = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
// Integer ALU with a zero flag used for equality branches.
// Assumes two's-complement operands; combinational.
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    // Select the result of the requested operation
    always_comb begin
        case (op)
            ALU_ADD:   y = a + b;
            ALU_SUB:   y = a - b;
            ALU_AND:   y = a & b;
            ALU_OR:    y = a | b;
            ALU_NOR:   y = ~(a | b);
            ALU_SLT:   y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_SLTU:  y = {{(W-1){1'b0}}, (a < b)};
            default:   y = b;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
// Register file: two operand read ports, one probe read port, one write.
// Assumes entry 0 is hard zero; two entries carry non-zero reset values.
module sc_regfile #(
    parameter int           W        = 32,
    parameter int           N        = 32,
    parameter int           SP_IDX   = 29,
    parameter int           GP_IDX   = 28,
    parameter logic [W-1:0] SP_RESET = 32'h0000_FFFC,
    parameter logic [W-1:0] GP_RESET = 32'h0000_C000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [$clog2(N)-1:0] ra1,
    input  logic [$clog2(N)-1:0] ra2,
    input  logic [$clog2(N)-1:0] ra3,
    output logic [W-1:0]         rd1,
    output logic [W-1:0]         rd2,
    output logic [W-1:0]         rd3,
    input  logic                 we,
    input  logic [$clog2(N)-1:0] wa,
    input  logic [W-1:0]         wd
);
    localparam int IW = $clog2(N);

    logic [W-1:0] regs [N];

    function automatic logic [W-1:0] reset_word(input int k);
        if (k == SP_IDX)      return SP_RESET;
        else if (k == GP_IDX) return GP_RESET;
        else                  return '0;
    endfunction

    // Reset every entry, then accept one write per cycle (never to entry 0)
    always_ff @(posedge clk) begin
        for (int k = 0; k < N; k++) begin
            if (!rst_n)
                regs[k] <= reset_word(k);
            else if (we && (k != 0) && (wa == IW'(k)))
                regs[k] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
    assign rd3 = (ra3 == '0) ? '0 : regs[ra3];
endmodule

// File: rtl/sc_store.sv
// Unified word store with an instruction read, a data read/write and a
// host read/write port. Assumes WORDS is a power of two; host wins on
// a write collision. Contents are not reset.
module sc_store #(
    parameter int W     = 32,
    parameter int WORDS = 4096
) (
    input  logic                     clk,
    input  logic [$clog2(WORDS)-1:0] i_idx,
    output logic [W-1:0]             i_data,
    input  logic [$clog2(WORDS)-1:0] d_idx,
    output logic [W-1:0]             d_rdata,
    input  logic                     d_we,
    input  logic [W-1:0]             d_wdata,
    input  logic [$clog2(WORDS)-1:0] h_idx,
    output logic [W-1:0]             h_rdata,
    input  logic                     h_we,
    input  logic [W-1:0]             h_wdata
);
    logic [W-1:0] cells [WORDS];

    // One write per edge, host first
    always_ff @(posedge clk) begin
        if (h_we)
            cells[h_idx] <= h_wdata;
        else if (d_we)
            cells[d_idx] <= d_wdata;
    end

    assign i_data  = cells[i_idx];
    assign d_rdata = cells[d_idx];
    assign h_rdata = cells[h_idx];
endmodule

// File: rtl/sc_core.sv
// Single-cycle core top: one instruction per enabled edge, sticky halt.
// Assumes a 64 KiB byte address space folded onto STORE_WORDS words.
module sc_core
    import sc_pkg::*;
#(
    parameter int          SPACE_BYTES = 65536,
    parameter int          STORE_WORDS = 4096,
    parameter logic [31:0] RESET_PC    = 32'h0000_4000,
    parameter logic [31:0] SP_RESET    = 32'h0000_FFFC,
    parameter logic [31:0] GP_RESET    = 32'h0000_C000,
    localparam int         STORE_IDX_W = $clog2(STORE_WORDS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   step_en,
    input  logic                   host_we,
    input  logic [STORE_IDX_W-1:0] host_idx,
    input  logic [31:0]            host_wdata,
    output logic [31:0]            host_rdata,
    input  logic [4:0]             probe_sel,
    output logic [31:0]            probe_data,
    output logic [31:0]            pc_o,
    output logic                   halt_o
);
    localparam logic [31:0] SPACE_LIMIT = 32'(SPACE_BYTES);

    logic [31:0] pc_q;
    logic        halt_q;
    logic [31:0] instr;
    ctrl_t       ctrl;

    logic [REG_IDX_W-1:0] f_rs, f_rt, f_rd, dst;
    logic [15:0]          f_imm;
    logic [25:0]          f_tgt;

    logic [31:0] op_a, op_b, imm_ext, alu_b, alu_y, ld_data, wb_data;
    logic [31:0] pc_plus4, br_target, jmp_target, pc_next;
    logic        alu_zero;
    logic        fetch_ok, data_ok, fault, go, commit;

    // Field split
    assign f_rs  = instr[25:21];
    assign f_rt  = instr[20:16];
    assign f_rd  = instr[15:11];
    assign f_imm = instr[15:0];
    assign f_tgt = instr[25:0];

    sc_store #(.W(XLEN), .WORDS(STORE_WORDS)) u_store (
        .clk     (clk),
        .i_idx   (pc_q[STORE_IDX_W+1:2]),
        .i_data  (instr),
        .d_idx   (alu_y[STORE_IDX_W+1:2]),
        .d_rdata (ld_data),
        .d_we    (commit && ctrl.mem_wr),
        .d_wdata (op_b),
        .h_idx   (host_idx),
        .h_rdata (host_rdata),
        .h_we    (host_we),
        .h_wdata (host_wdata)
    );

    sc_decode u_decode (
        .instr (instr),
        .ctrl  (ctrl)
    );

    sc_regfile #(
        .W        (XLEN),
        .N        (NREGS),
        .SP_IDX   (29),
        .GP_IDX   (28),
        .SP_RESET (SP_RESET),
        .GP_RESET (GP_RESET)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (f_rs),
        .ra2   (f_rt),
        .ra3   (probe_sel),
        .rd1   (op_a),
        .rd2   (op_b),
        .rd3   (probe_data),
        .we    (commit && ctrl.reg_we),
        .wa    (dst),
        .wd    (wb_data)
    );

    // Immediate forming: upper-half placement or sign extension from bit 15
    assign imm_ext = ctrl.imm_hi ? {f_imm, 16'h0000} : {{16{f_imm[15]}}, f_imm};
    assign alu_b   = ctrl.b_imm ? imm_ext : op_b;

    sc_alu #(.W(XLEN)) u_alu (
        .a    (op_a),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Write-back selection
    assign dst     = ctrl.dst_rd ? f_rd : f_rt;
    assign wb_data = ctrl.mem_rd ? ld_data : alu_y;

    // Legality of this step
    assign fetch_ok = (pc_q[1:0] == 2'b00) && (pc_q < SPACE_LIMIT);
    assign data_ok  = !(ctrl.mem_rd || ctrl.mem_wr) ||
                      ((alu_y[1:0] == 2'b00) && (alu_y < SPACE_LIMIT));
    assign fault    = !fetch_ok || !ctrl.legal || !data_ok;
    assign go       = step_en && !host_we && !halt_q;
    assign commit   = go && !fault;

    // Next-PC selection
    assign pc_plus4   = pc_q + 32'd4;
    assign br_target  = pc_plus4 + {imm_ext[29:0], 2'b00};
    assign jmp_target = {pc_plus4[31:28], f_tgt, 2'b00};
    assign pc_next    = ctrl.jump                  ? jmp_target :
                        (ctrl.branch && alu_zero)  ? br_target  : pc_plus4;

    // PC register: reset vector, advance on commit only
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= RESET_PC;
        else if (commit)
            pc_q <= pc_next;
    end

    // Halt flag: set by a faulting step, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            halt_q <= 1'b0;
        else if (go && fault)
            halt_q <= 1'b1;
    end

    assign pc_o   = pc_q;
    assign halt_o = halt_q;
endmodule

// File: rtl/sc_core_chk.sv
// Port-level property checker for sc_core, attached by bind below.
// Assumes the same reset vector as the core it watches.
module sc_core_chk #(
    parameter logic [31:0] RESET_PC = 32'h0000_4000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        step_en,
    input logic        host_we,
    input logic [4:0]  probe_sel,
    input logic [31:0] probe_data,
    input logic [31:0] pc_o,
    input logic        halt_o
);
    p_reset_vector_r1: assert property (@(posedge clk)
        !rst_n |=> (pc_o == RESET_PC) && !halt_o);

    p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en || host_we) |=> $stable(pc_o) && $stable(halt_o));

    p_zero_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_sel == 5'd0) |-> (probe_data == 32'd0));

    p_halt_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> halt_o);

    p_halt_freezes_pc_r12: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> $stable(pc_o));

    p_halt_needs_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_o) |-> $past(step_en && !host_we));

    p_pc_aligned_r13: assert property (@(posedge clk) disable iff (!rst_n)
        pc_o[1:0] == 2'b00);
endmodule

bind sc_core sc_core_chk #(.RESET_PC(RESET_PC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en    (step_en),
    .host_we    (host_we),
    .probe_sel  (probe_sel),
    .probe_data (probe_data),
    .pc_o       (pc_o),
    .halt_o     (halt_o)
);

// File: tb/tb_sc_core.sv
// Bench for sc_core: directed corner cases plus seeded random programs,
// checked step by step against an instruction-level model in the bench.
module tb_sc_core;
    localparam int STORE_WORDS = 4096;
    localparam int IW          = $clog2(STORE_WORDS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          step_en = 1'b0;
    logic          host_we = 1'b0;
    logic [IW-1:0] host_idx = '0;
    logic [31:0]   host_wdata = '0;
    logic [31:0]   host_rdata;
    logic [4:0]    probe_sel = '0;
    logic [31:0]   probe_data;
    logic [31:0]   pc_o;
    logic          halt_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Model state
    logic [31:0] m_reg [32];
    logic [31:0] m_mem [STORE_WORDS];
    logic [31:0] m_pc;
    logic        m_halt;
    int          last_st = -1;

    always #4 clk = ~clk;   // 125 MHz

    sc_core #(.STORE_WORDS(STORE_WORDS)) dut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .host_we(host_we),
        .host_idx(host_idx), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .probe_sel(probe_sel), .probe_data(probe_data),
        .pc_o(pc_o), .halt_o(halt_o)
    );

    function automatic int widx(input logic [31:0] a);
        return int'((a >> 2) & 32'(STORE_WORDS - 1));
    endfunction

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt, input int rd);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] enc_j(input logic [25:0] t);
        return {6'h02, t};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 32; k++) m_reg[k] = 32'd0;
        m_reg[29] = 32'h0000_FFFC;
        m_reg[28] = 32'h0000_C000;
        m_pc   = 32'h0000_4000;
        m_halt = 1'b0;
        last_st = -1;
    endtask

    // Instruction-level reference for one step
    task automatic model_step();
        logic [31:0] ins, a, b, se, p4, npc, val, ad;
        logic [5:0]  op, fn;
        int          rs, rt, rd, dst;
        bit          wr, bad, st;
        last_st = -1;
        if (m_halt) return;
        if (m_pc[1:0] != 2'b00 || m_pc >= 32'h0001_0000) begin
            m_halt = 1'b1;
            return;
        end
        ins = m_mem[widx(m_pc)];
        op = ins[31:26]; fn = ins[5:0];
        rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
        a = m_reg[rs]; b = m_reg[rt];
        se = {{16{ins[15]}}, ins[15:0]};
        p4 = m_pc + 32'd4; npc = p4;
        wr = 1'b0; bad = 1'b0; st = 1'b0; val = '0; dst = rt; ad = a + se;
        case (op)
            6'h00: begin
                wr = 1'b1; dst = rd;
                case (fn)
                    6'h20: val = a + b;
                    6'h22: val = a - b;
                    6'h24: val = a & b;
                    6'h25: val = a | b;
                    6'h27: val = ~(a | b);
                    6'h2a: val = {31'd0, $signed(a) < $signed(b)};
                    6'h2b: val = {31'd0, a < b};
                    default: bad = 1'b1;
                endcase
            end
            6'h08: begin wr = 1'b1; val = a + se; end
            6'h0a: begin wr = 1'b1; val = {31'd0, $signed(a) < $signed(se)}; end
            6'h0b: begin wr = 1'b1; val = {31'd0, a < se}; end
            6'h0f: begin wr = 1'b1; val = {ins[15:0], 16'h0000}; end
            6'h23: begin
                if (ad[1:0] != 2'b00 || ad >= 32'h0001_0000) bad = 1'b1;
                else begin wr = 1'b1; val = m_mem[widx(ad)]; end
            end
            6'h2b: begin
                if (ad[1:0] != 2'b00 || ad >= 32'h0001_0000) bad = 1'b1;
                else st = 1'b1;
            end
            6'h04: if (a == b) npc = p4 + {se[29:0], 2'b00};
            6'h02: npc = {p4[31:28], ins[25:0], 2'b00};
            default: bad = 1'b1;
        endcase
        if (bad) begin
            m_halt = 1'b1;
            return;
        end
        if (wr && dst != 0) m_reg[dst] = val;
        if (st) begin
            m_mem[widx(ad)] = b;
            last_st = widx(ad);
        end
        m_pc = npc;
    endtask

    task automatic host_load(input int ix, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_idx = IW'(ix); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        m_mem[ix] = d;
    endtask

    task automatic mem_check(input int ix, input string tag);
        host_idx = IW'(ix);
        #1;
        chk(tag, host_rdata, m_mem[ix]);
    endtask

    // Compare PC, halt, alignment, all registers and the last stored word
    task automatic compare_state(input string tag);
        chk(tag, pc_o, m_pc);
        chk({tag, " halt"}, {31'd0, halt_o}, {31'd0, m_halt});
        chk("R13 pc alignment", {30'd0, pc_o[1:0]}, 32'd0);
        for (int k = 0; k < 32; k++) begin
            probe_sel = 5'(k);
            #1;
            chk((k == 0) ? "R8 reg0" : tag, probe_data, m_reg[k]);
        end
        if (last_st >= 0) mem_check(last_st, "R5 stored word");
    endtask

    task automatic exec(input logic [31:0] ins, input string tag);
        host_load(widx(m_pc), ins);
        @(negedge clk); step_en = 1'b1;
        @(negedge clk); step_en = 1'b0;
        model_step();
        compare_state(tag);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        model_reset();
    endtask

    function automatic logic [31:0] rand_instr(output string tag);
        int k;
        logic [5:0] fns [7];
        fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25;
        fns[4] = 6'h27; fns[5] = 6'h2a; fns[6] = 6'h2b;
        k = int'($urandom % 9);
        case (k)
            3: begin
                logic [5:0] ops [4];
                ops[0] = 6'h08; ops[1] = 6'h0a; ops[2] = 6'h0b; ops[3] = 6'h0f;
                tag = "R4 random immediate";
                return enc_i(ops[$urandom % 4], int'($urandom % 32), int'($urandom % 16), 16'($urandom));
            end
            4: begin
                tag = "R5 random load";
                return enc_i(6'h23, 28, int'($urandom % 16), 16'((int'($urandom % 64) - 32) * 4));
            end
            5: begin
                tag = "R5 random store";
                return enc_i(6'h2b, 28, int'($urandom % 32), 16'((int'($urandom % 64) - 32) * 4));
            end
            6: begin
                tag = "R6 random branch";
                return enc_i(6'h04, int'($urandom % 4), int'($urandom % 4), 16'(int'($urandom % 17) - 8));
            end
            7: begin
                tag = "R7 random jump";
                return enc_j(26'(32'h1000 + ($urandom % 32'h2F00)));
            end
            default: begin
                tag = "R3 random register op";
                return enc_r(fns[$urandom % 7], int'($urandom % 32), int'($urandom % 32), int'($urandom % 16));
            end
        endcase
    endfunction

    // Watchdog: a hung run counts as one failure
    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        string tg;
        logic [31:0] ins;
        void'($urandom(32'd20240611));

        // Clear the store so every load sees known data
        for (int k = 0; k < STORE_WORDS; k++) m_mem[k] = 32'd0;
        @(negedge clk);
        host_we = 1'b1; host_wdata = 32'd0;
        for (int k = 0; k < STORE_WORDS; k++) begin
            host_idx = IW'(k);
            @(negedge clk);
        end
        host_we = 1'b0;
        do_reset();
        compare_state("R1 reset state");

        // R2: host write in the same cycle as step_en blocks the step
        ins = enc_i(6'h08, 0, 1, 16'd5);
        @(negedge clk);
        step_en = 1'b1; host_we = 1'b1; host_idx = IW'(widx(m_pc)); host_wdata = ins;
        @(negedge clk);
        step_en = 1'b0; host_we = 1'b0;
        m_mem[widx(m_pc)] = ins;
        compare_state("R2 step blocked by host write");
        mem_check(widx(m_pc), "R2 host write landed");
        repeat (3) @(negedge clk);
        compare_state("R2 idle cycles");
        @(negedge clk); step_en = 1'b1;
        @(negedge clk); step_en = 1'b0;
        model_step();
        compare_state("R4 addi after gating");

        // Directed datapath cases
        exec(enc_i(6'h08, 0, 2, 16'hFFFD), "R4 addi negative");
        exec(enc_i(6'h08, 0, 3, 16'd7), "R4 addi positive");
        exec(enc_r(6'h2a, 2, 3, 4), "R3 slt signed");
        exec(enc_r(6'h2b, 2, 3, 5), "R3 sltu unsigned");
        exec(enc_r(6'h27, 1, 3, 6), "R3 nor");
        exec(enc_r(6'h22, 1, 3, 7), "R3 sub wraps");
        exec(enc_i(6'h0b, 2, 8, 16'hFFFF), "R4 sltiu sign-extended");
        exec(enc_i(6'h0a, 2, 11, 16'hFFFF), "R4 slti");
        exec(enc_i(6'h0f, 0, 9, 16'h8001), "R4 lui");
        exec(enc_i(6'h2b, 28, 9, 16'hFFF8), "R5 store below gp");
        exec(enc_i(6'h23, 28, 10, 16'hFFF8), "R5 load back");
        exec(enc_r(6'h20, 1, 1, 0), "R8 write to reg0");
        exec(enc_i(6'h04, 1, 1, 16'd3), "R6 branch taken");
        exec(enc_i(6'h04, 1, 2, 16'hFFFE), "R6 branch not taken");
        exec(enc_j(26'h1800), "R7 jump");

        // Seeded random program
        for (int n = 0; n < 400; n++) begin
            ins = rand_instr(tg);
            exec(ins, tg);
        end

        // R11: unknown function code, then sticky halt
        exec(enc_r(6'h3f, 1, 2, 3), "R11 unknown function");
        exec(enc_i(6'h08, 0, 4, 16'd9), "R12 step after halt");
        exec(enc_j(26'h1000), "R12 jump after halt");
        do_reset();
        compare_state("R12 reset clears halt");

        // R11: unknown opcode
        exec(enc_i(6'h3f, 0, 1, 16'd1), "R11 unknown opcode");
        do_reset();

        // R10: unaligned load, then store one word past the space
        exec(enc_i(6'h23, 28, 1, 16'd2), "R10 unaligned load");
        do_reset();
        exec(enc_i(6'h08, 0, 1, 16'h1234), "R4 setup value");
        exec(enc_i(6'h2b, 29, 1, 16'd4), "R10 store out of range");
        mem_check(widx(32'h0001_0000), "R10 aliased word untouched");
        do_reset();

        // R9: jump to the end of the space, then fetch there
        exec(enc_j(26'h4000), "R7 jump to 0x10000");
        exec(enc_i(6'h08, 0, 1, 16'd1), "R9 fetch out of range");
        exec(enc_i(6'h08, 0, 1, 16'd1), "R12 still halted");

        finish_run();
    end
endmodule